// File: doc/BRIEF.md
# Half-Integer Clock Divider Branch

This block is one branch of a clock tree. One of two source clocks is picked by a glitch-free selector. The selected clock passes through a clock gate and then reaches a divider whose ratio is always a whole number plus one half. The divider counts on both edges of its input clock, so an output period can span an odd number of input half-periods. For a field value `v`, the output frequency is the input frequency multiplied by 2/(2·v+3). A value of 0 therefore divides by 1.5, and each step of `v` adds 1.0 to the ratio.

The branch is set up through two 16-bit configuration words on a 32-bit bus. Every write is masked: bit `i+16` of the written word lets bit `i` change, and every other bit keeps its value. Software can therefore update one field without reading the word first. The selector and the divider fields share word 0. The gate enable sits in word 1.

Each stage (selector, gate, divider) can be removed by parameter. The selector can also be built read-only, in which case it always uses source 0.

Top module: `hdb_branch`

## Requirements
- R1: A write changes bit `i` (0..15) of the addressed word only when bit `i+16` of `cfg_wdata` is 1. A write whose upper half-word is zero leaves both the readback and the output clock unchanged.
- R2: `cfg_rdata` returns the word chosen by `cfg_addr` in the same cycle. In word 0, the divider field is at bits 3:0 and the source select is at bit 8. In word 1, the gate enable is at bit 0. All other bits, including bits 31:16, read as 0, even after writes that try to set them.
- R3: After reset, word 0 reads 0x00000000 and word 1 reads 0x00000001. The output runs at source 0 divided by 1.5.
- R4: For a divider value `v`, one output period lasts 2·v+3 half-periods of the selected source. This holds for v = 0 up to the field maximum of 15.
- R5: Within each period, the output is high for v+1 source half-periods and low for v+2.
- R6: A new divider value takes effect only at a boundary between two output periods. While the value changes, no high or low phase is shorter than the shorter of the old and new phases.
- R7: Select value 0 picks source 0 and value 1 picks source 1. The two source enables are never active together. A changeover produces no high or low phase shorter than the shortest legal phase of either source.
- R8: With the gate bit at 0, the output stops toggling. Setting the bit back to 1 restores the programmed waveform. No phase is cut short while the gate changes.
- R9: When the selector is built read-only, writes to bit 8 are ignored, bit 8 reads 0, and the output stays on source 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration bus clock |
| rst_n | input | 1 | Active-low reset, sampled on clock edges; hold it for several cycles of every clock |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 1 | Word select: 0 = divider and source select, 1 = gate |
| cfg_wdata | input | 32 | Write word; the upper half holds per-bit write enables for the lower half |
| cfg_rdata | output | 32 | Readback of the addressed word |
| src0_clk | input | 1 | Source clock 0 |
| src1_clk | input | 1 | Source clock 1 |
| clk_out | output | 1 | Divided branch clock |

## Verification
A wrong configuration bit shows on `cfg_rdata` on the first cycle after the write. A wrong divider count or a mistimed toggle shows within one output period as a high or low phase whose length is not a whole multiple of the expected source half-period. A broken update or changeover shows as a phase shorter than any legal one during the transition. A stuck gate shows as edges that should not be there, or as missing edges, within a few tens of bus cycles.

// File: rtl/hdb_pkg.sv
// Package: shared word geometry and the masked-merge rule for configuration writes.
// Assumes a 32-bit bus whose upper half-word carries per-bit write enables.
package hdb_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [HALF_W-1:0] half_t;

    // Merge a masked write into the current lower half-word.
    function automatic half_t masked_merge(half_t cur, logic [WORD_W-1:0] wd);
        half_t en;
        en = wd[WORD_W-1:HALF_W];
        return (cur & ~en) | (wd[HALF_W-1:0] & en);
    endfunction
endpackage

// File: rtl/hdb_regs.sv
// Configuration words with masked writes and combinational readback.
// Assumes every field lies within bits 15:0. Bits that no field owns are never stored.
module hdb_regs
    import hdb_pkg::*;
#(
    parameter int DIV_W     = 4,
    parameter int DIV_SHIFT = 0,
    parameter int SEL_SHIFT = 8,
    parameter int GATE_ADDR = 1,
    parameter int GATE_BIT  = 0,
    parameter bit HAS_MUX   = 1'b1,
    parameter bit MUX_RO    = 1'b0,
    parameter bit HAS_GATE  = 1'b1,
    parameter bit HAS_DIV   = 1'b1
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output half_t             r0_o,
    output half_t             r1_o,
    output logic [DIV_W-1:0]  div_val_o,
    output logic              sel_o,
    output logic              gate_en_o
);
    localparam half_t DIV_M  = HAS_DIV ? half_t'(((32'd1 << DIV_W) - 32'd1) << DIV_SHIFT) : '0;
    localparam half_t SEL_M  = (HAS_MUX && !MUX_RO) ? half_t'(32'd1 << SEL_SHIFT) : '0;
    localparam half_t GATE_M = HAS_GATE ? half_t'(32'd1 << GATE_BIT) : '0;
    localparam half_t W0_M   = DIV_M | SEL_M | ((GATE_ADDR == 0) ? GATE_M : '0);
    localparam half_t W1_M   = (GATE_ADDR == 1) ? GATE_M : '0;
    localparam half_t R0_RST = (GATE_ADDR == 0) ? GATE_M : '0;
    localparam half_t R1_RST = (GATE_ADDR == 1) ? GATE_M : '0;

    half_t r0_q, r1_q;

    // Store masked writes, keeping only the bits that some field owns.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            r0_q <= R0_RST;
            r1_q <= R1_RST;
        end else if (cfg_wr) begin
            if (!cfg_addr) r0_q <= masked_merge(r0_q, cfg_wdata) & W0_M;
            else           r1_q <= masked_merge(r1_q, cfg_wdata) & W1_M;
        end
    end

    assign cfg_rdata = {{HALF_W{1'b0}}, (cfg_addr ? r1_q : r0_q)};
    assign r0_o      = r0_q;
    assign r1_o      = r1_q;
    assign div_val_o = r0_q[DIV_SHIFT +: DIV_W];
    assign sel_o     = r0_q[SEL_SHIFT];

    if (!HAS_GATE) begin : g_no_gate
        assign gate_en_o = 1'b1;
    end else if (GATE_ADDR == 1) begin : g_gate_w1
        assign gate_en_o = r1_q[GATE_BIT];
    end else begin : g_gate_w0
        assign gate_en_o = r0_q[GATE_BIT];
    end
endmodule

// File: rtl/hdb_src_mux.sv
// Glitch-free two-source clock selector.
// Each source owns an enable that is built in two stages: a rising-edge stage
// and then a falling-edge stage. A source may enable only after it has seen the
// other source's enable low, so the output stays low through a changeover.
// Assumes both sources keep running while reset is held.
module hdb_src_mux #(
    parameter bit HAS_MUX = 1'b1
) (
    input  logic       src0_i,
    input  logic       src1_i,
    input  logic       rst_n,
    input  logic       sel_i,
    output logic       clk_o,
    output logic [1:0] en_o
);
    if (HAS_MUX) begin : g_mux
        logic [1:0] src;
        assign src = {src1_i, src0_i};

        for (genvar i = 0; i < 2; i++) begin : g_src
            logic req, stg_q, en_q;
            assign req = (sel_i == 1'(i)) && !en_o[1-i];

            // First stage: capture the request on the rising edge of this source.
            always_ff @(posedge src[i]) begin
                if (!rst_n) stg_q <= (i == 0);
                else        stg_q <= req;
            end

            // Second stage: move the enable only while this source is low.
            always_ff @(negedge src[i]) begin
                if (!rst_n) en_q <= (i == 0);
                else        en_q <= stg_q;
            end

            assign en_o[i] = en_q;
        end

        assign clk_o = |(src & en_o);
    end else begin : g_bypass
        assign clk_o = src0_i;
        assign en_o  = 2'b01;
    end
endmodule

// File: rtl/hdb_gate.sv
// Clock gate. The enable is synchronised on the rising edge and applied on the
// falling edge, so a high phase is never cut short.
// Assumes the input clock runs during reset.
module hdb_gate #(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en_i,
    output logic clk_o
);
    if (HAS_GATE) begin : g_gate
        logic sync_q, en_q;

        // Bring the enable into the clock domain.
        always_ff @(posedge clk_i) begin
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= en_i;
        end

        // Change the applied enable only while the clock is low.
        always_ff @(negedge clk_i) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= sync_q;
        end

        assign clk_o = clk_i & en_q;
    end else begin : g_bypass
        assign clk_o = clk_i;
    end
endmodule

// File: rtl/hdb_div.sv
// Half-integer divider: output period = 2*v+3 input half-periods, high for v+1.
// One rising-edge counter spans a pair of output periods (2*v+3 input cycles).
// A rising-edge flop and a falling-edge flop each toggle twice per pair, and the
// output is their XOR. The ratio is loaded when the counter wraps, at which point
// the output is low.
module hdb_div #(
    parameter int DIV_W   = 4,
    parameter bit HAS_DIV = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_val_i,
    output logic               clk_o,
    output logic [DIV_W+1:0]   cnt_o,
    output logic [DIV_W-1:0]   act_o
);
    localparam int CNT_W = DIV_W + 2;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t C1 = cnt_t'(1);
    localparam cnt_t C2 = cnt_t'(2);
    localparam cnt_t C3 = cnt_t'(3);
    localparam cnt_t C4 = cnt_t'(4);

    if (HAS_DIV) begin : g_div
        cnt_t             cnt_q, vx, last_c, tp, tn_a, tn_b;
        logic [DIV_W-1:0] v_q;
        logic             p_q, n_q;

        assign vx     = {2'b00, v_q};
        assign last_c = vx + vx + C2;

        // Event positions inside the pair; odd and even ratios place them differently.
        always_comb begin
            if (v_q[0]) begin
                tp   = (vx + C1) >> 1;
                tn_a = vx + C1;
                tn_b = (vx + vx + vx + C3) >> 1;
            end else begin
                tp   = (vx + vx + vx + C4) >> 1;
                tn_a = vx >> 1;
                tn_b = vx + C1;
            end
        end

        // Rising edge: advance the pair counter, load the ratio at the wrap, toggle p.
        always_ff @(posedge clk_i) begin
            if (!rst_n) begin
                cnt_q <= C2;
                v_q   <= '0;
                p_q   <= 1'b0;
            end else if (cnt_q == last_c) begin
                cnt_q <= '0;
                v_q   <= div_val_i;
                p_q   <= ~p_q;
            end else begin
                cnt_q <= cnt_q + C1;
                if (cnt_q + C1 == tp) p_q <= ~p_q;
            end
        end

        // Falling edge: toggle n at the mid-cycle event positions.
        always_ff @(negedge clk_i) begin
            if (!rst_n)                           n_q <= 1'b0;
            else if (cnt_q == tn_a || cnt_q == tn_b) n_q <= ~n_q;
        end

        assign clk_o = p_q ^ n_q;
        assign cnt_o = cnt_q;
        assign act_o = v_q;
    end else begin : g_bypass
        assign clk_o = clk_i;
        assign cnt_o = '0;
        assign act_o = '0;
    end
endmodule

// File: rtl/hdb_branch.sv
// Clock branch: source selector, then gate, then half-integer divider, all
// configured through masked-write words. Assumes rst_n is held for several
// cycles of cfg_clk and of both sources.
module hdb_branch #(
    parameter int DIV_W     = 4,
    parameter int DIV_SHIFT = 0,
    parameter int SEL_SHIFT = 8,
    parameter int GATE_ADDR = 1,
    parameter int GATE_BIT  = 0,
    parameter bit HAS_MUX   = 1'b1,
    parameter bit MUX_RO    = 1'b0,
    parameter bit HAS_GATE  = 1'b1,
    parameter bit HAS_DIV   = 1'b1
) (
    input  logic        cfg_clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        src0_clk,
    input  logic        src1_clk,
    output logic        clk_out
);
    logic [15:0]      reg0_w, reg1_w;
    logic [DIV_W-1:0] div_val, div_act;
    logic [DIV_W+1:0] div_cnt;
    logic             sel, gate_en, mux_clk, gated_clk;
    logic [1:0]       mux_en;

    hdb_regs #(
        .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .SEL_SHIFT(SEL_SHIFT),
        .GATE_ADDR(GATE_ADDR), .GATE_BIT(GATE_BIT), .HAS_MUX(HAS_MUX),
        .MUX_RO(MUX_RO), .HAS_GATE(HAS_GATE), .HAS_DIV(HAS_DIV)
    ) regs_i (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .r0_o(reg0_w), .r1_o(reg1_w),
        .div_val_o(div_val), .sel_o(sel), .gate_en_o(gate_en)
    );

    hdb_src_mux #(.HAS_MUX(HAS_MUX)) mux_i (
        .src0_i(src0_clk), .src1_i(src1_clk), .rst_n(rst_n), .sel_i(sel),
        .clk_o(mux_clk), .en_o(mux_en)
    );

    hdb_gate #(.HAS_GATE(HAS_GATE)) gate_i (
        .clk_i(mux_clk), .rst_n(rst_n), .en_i(gate_en), .clk_o(gated_clk)
    );

    hdb_div #(.DIV_W(DIV_W), .HAS_DIV(HAS_DIV)) div_i (
        .clk_i(gated_clk), .rst_n(rst_n), .div_val_i(div_val),
        .clk_o(clk_out), .cnt_o(div_cnt), .act_o(div_act)
    );
endmodule

// File: rtl/hdb_branch_chk.sv
// Checker for hdb_branch: configuration write rules, reset fields, selector
// exclusivity and divider counter behaviour. Attached to the top by bind.
module hdb_branch_chk #(
    parameter int DIV_W     = 4,
    parameter int DIV_SHIFT = 0,
    parameter int SEL_SHIFT = 8
) (
    input logic             cfg_clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_addr,
    input logic [31:0]      cfg_wdata,
    input logic [15:0]      r0,
    input logic [15:0]      r1,
    input logic [1:0]       mux_en,
    input logic             gated_clk,
    input logic [DIV_W+1:0] div_cnt,
    input logic [DIV_W-1:0] div_act
);
    // R1: a write with no enable bits set leaves both words unchanged.
    assert_unmasked_hold_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[31:16] == 16'h0) |=> ($stable(r0) && $stable(r1)));

    // R1: an enabled bit of the divider field takes the written value.
    assert_masked_set_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cfg_wr && !cfg_addr && cfg_wdata[16 + DIV_SHIFT])
        |=> (r0[DIV_SHIFT] == $past(cfg_wdata[DIV_SHIFT])));

    // R3: right after reset, the divider and select fields are zero.
    assert_reset_fields_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r0[DIV_SHIFT +: DIV_W] == '0 && r0[SEL_SHIFT] == 1'b0));

    // R7: the two source enables are never active together.
    assert_src_exclusive_R7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(mux_en));

    // R4: the pair counter stays below 2*v+3.
    assert_cnt_range_R4: assert property (@(posedge gated_clk) disable iff (!rst_n)
        int'(div_cnt) < 2 * int'(div_act) + 3);

    // R6: the active ratio changes only at the start of a period pair.
    assert_load_at_wrap_R6: assert property (@(posedge gated_clk) disable iff (!rst_n)
        !$stable(div_act) |-> (div_cnt == '0));
endmodule

bind hdb_branch hdb_branch_chk #(
    .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .SEL_SHIFT(SEL_SHIFT)
) chk_i (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .r0(reg0_w), .r1(reg1_w), .mux_en(mux_en),
    .gated_clk(gated_clk), .div_cnt(div_cnt), .div_act(div_act)
);

// File: tb/hdb_branch_tb_top.sv
// Bench: a behavioural model of the configuration words is compared on every
// bus clock, and every output phase is timed against 2*v+3 half-periods.
module hdb_branch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SRC0_HALF  = 3;
    localparam int SRC1_HALF  = 7;

    logic        cfg_clk = 1'b0, src0_clk = 1'b0, src1_clk = 1'b0;
    logic        rst_n = 1'b0, cfg_wr = 1'b0, cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata, ro_rdata;
    logic        clk_out, ro_clk;

    int checks = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) cfg_clk = ~cfg_clk;
    initial begin #1; forever #(SRC0_HALF) src0_clk = ~src0_clk; end
    initial begin #2; forever #(SRC1_HALF) src1_clk = ~src1_clk; end

    hdb_branch dut_i (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src0_clk(src0_clk),
        .src1_clk(src1_clk), .clk_out(clk_out)
    );

    hdb_branch #(.MUX_RO(1'b1)) dut_ro_i (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(ro_rdata), .src0_clk(src0_clk),
        .src1_clk(src1_clk), .clk_out(ro_clk)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(string tag, int act, int lim);
        checks++;
        if (act < lim) begin
            bad++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    // Reference model of the two words (word 0: bits 3:0 and 8 writable; word 1: bit 0).
    logic [15:0] m0, m1;
    always @(posedge cfg_clk) begin
        if (!rst_n) begin
            m0 <= 16'h0000;
            m1 <= 16'h0001;
        end else if (cfg_wr) begin
            for (int i = 0; i < 16; i++) begin
                if (cfg_wdata[16 + i]) begin
                    if (!cfg_addr && (i < 4 || i == 8)) m0[i] <= cfg_wdata[i];
                    if (cfg_addr && i == 0)             m1[i] <= cfg_wdata[i];
                end
            end
        end
    end

    // R2: readback compared with the model on every bus clock, away from the edges.
    always @(posedge cfg_clk) begin
        #(CLK_PERIOD / 4);
        if (rst_n && !done)
            chk("R2 readback vs model", int'(cfg_rdata), int'({16'h0, (cfg_addr ? m1 : m0)}));
    end

    // Phase timing monitor on the divided clock.
    int t_last = 0, hi_w = 0, lo_w = 0, edges = 0;
    int min_hi = 1000000, min_lo = 1000000;
    bit win = 1'b0;
    always @(clk_out) begin
        if (clk_out === 1'b0) begin
            hi_w = int'($time) - t_last;
            if (win && hi_w < min_hi) min_hi = hi_w;
        end else begin
            lo_w = int'($time) - t_last;
            if (win && lo_w < min_lo) min_lo = lo_w;
        end
        t_last = int'($time);
        edges++;
    end

    task automatic wr(bit a, logic [31:0] d);
        @(negedge cfg_clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge cfg_clk);
        cfg_wr = 1'b0; cfg_wdata = 32'h0;
    endtask

    task automatic rd(bit a, int exp, string tag);
        @(negedge cfg_clk);
        cfg_addr = a;
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    task automatic settle();
        repeat (8) @(posedge clk_out);
    endtask

    task automatic meas(string tag, int v, int half);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk_out); #1;
            chk({tag, " high phase"}, hi_w, (v + 1) * half);
            @(posedge clk_out); #1;
            chk({tag, " low phase"}, lo_w, (v + 2) * half);
        end
    endtask

    task automatic open_win();
        min_hi = 1000000; min_lo = 1000000; win = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge cfg_clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog (R1..R9 unfinished) actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int e0, t0;
        repeat (20) @(negedge cfg_clk);
        rst_n = 1'b1;

        rd(1'b0, 32'h0, "R3 word0 reset");
        rd(1'b1, 32'h1, "R3 word1 reset");
        settle();
        meas("R3 R4 R5 v0 src0", 0, SRC0_HALF);

        wr(1'b0, 32'h000F_0005);
        rd(1'b0, 32'h5, "R1 enabled write");
        settle();
        meas("R4 R5 v5", 5, SRC0_HALF);

        wr(1'b0, 32'h0000_FFFF);
        rd(1'b0, 32'h5, "R1 write without enables");
        settle();
        meas("R1 output unchanged", 5, SRC0_HALF);

        wr(1'b0, 32'h40F2_FFFF);
        rd(1'b0, 32'h7, "R2 non-field bits stay zero");
        settle();
        meas("R1 R4 v7", 7, SRC0_HALF);

        open_win();
        wr(1'b0, 32'h000F_0002);
        settle();
        win = 1'b0;
        chk_ge("R6 shortest high in update", min_hi, 3 * SRC0_HALF);
        chk_ge("R6 shortest low in update", min_lo, 4 * SRC0_HALF);
        meas("R6 R4 v2", 2, SRC0_HALF);

        wr(1'b0, 32'h000F_000F);
        settle();
        meas("R4 R5 v15 max", 15, SRC0_HALF);

        wr(1'b0, 32'h000F_0001);
        settle();
        meas("R4 R5 v1", 1, SRC0_HALF);

        open_win();
        wr(1'b0, 32'h0100_0100);
        rd(1'b0, 32'h101, "R7 select readback");
        chk("R9 read-only select ignored", int'(ro_rdata), 32'h1);
        settle();
        win = 1'b0;
        chk_ge("R7 shortest high in switch", min_hi, 2 * SRC0_HALF);
        chk_ge("R7 shortest low in switch", min_lo, 3 * SRC0_HALF);
        meas("R7 src1 v1", 1, SRC1_HALF);
        @(posedge ro_clk); t0 = int'($time);
        @(negedge ro_clk); #1;
        chk("R9 read-only branch stays on src0", int'($time) - 1 - t0, 2 * SRC0_HALF);

        wr(1'b0, 32'h0100_0000);
        settle();
        meas("R7 back to src0", 1, SRC0_HALF);

        open_win();
        wr(1'b1, 32'h0001_0000);
        repeat (10) @(negedge cfg_clk);
        e0 = edges;
        repeat (40) @(negedge cfg_clk);
        chk("R8 gated off no edges", edges, e0);
        rd(1'b1, 32'h0, "R8 gate readback off");
        wr(1'b1, 32'h0001_0001);
        settle();
        win = 1'b0;
        chk_ge("R8 shortest high around gate", min_hi, 2 * SRC0_HALF);
        chk_ge("R8 shortest low around gate", min_lo, 3 * SRC0_HALF);
        meas("R8 resumed", 1, SRC0_HALF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule